// File: doc/BRIEF.md
# Flow Shunting Lookup Engine

The engine sits behind a packet decoder and decides, per packet descriptor, whether the packet stays in hardware or goes to host software. Each descriptor carries four 32-bit field slots taken by the decoder from the packet, a byte length and an order tag. A per-slot enable mask picks which slots form the lookup key. Disabled slots are forced to zero. A CRC of the key selects one slot of a direct-mapped table that holds the full key, a drop/forward action, an output port and per-flow packet and byte counters.

On a hit the stored action is applied and the counters are written back in the same pass. The output descriptor reports the updated counts. On a miss the descriptor is marked for the host. The host inspects the packet and then installs the flow through a learn/unlearn command port. That port accepts one command per cycle alongside the lookup stream and answers each command with a status one cycle later.

Top module: `flow_shunt`

## Requirements
- R1: After reset out_valid_o and rsp_valid_o are low and the table is empty, so every lookup misses until a flow is learned.
- R2: Slot j of a field bus occupies bits [32*j +: 32]. The slot takes part in the key only when cfg_field_en_i[j] is 1, and a disabled slot is zeroed. Packets that differ only in disabled slots therefore hit the same entry.
- R3: The slot layout is: slot0 source IP, slot1 destination IP, slot2 {source port, destination port}, slot3 protocol in bits [7:0]. The mask 4'b1111 gives the 5-tuple, 4'b0111 the 4-tuple and 4'b0011 the 2-tuple. In the 2-tuple profile a fragment that carries zero ports and another protocol hits the entry learned from a full packet.
- R4: On a hit with a drop entry out_dest_o is 0 and out_port_o is 0. On a hit with a forward entry out_dest_o is 1 and out_port_o is the stored port.
- R5: On a miss out_dest_o is 2 (host), and out_port_o, out_pkts_o and out_bytes_o are 0.
- R6: Every hit writes back the entry. out_pkts_o is the entry's packet count including this packet, and out_bytes_o is the sum of in_len_i over those packets. A learn clears both counters.
- R7: The learn index is bits [5:0] of a CRC-16 over the 128-bit masked key: polynomial 0x1021, initial value 0xFFFF, key bit 127 first, no reflection, no final XOR. A learn to an empty slot or to a slot holding the same key installs the entry and returns status 0. A learn to a slot holding another key returns status 1 and changes nothing.
- R8: An unlearn whose key is present removes the entry and returns status 0. Otherwise it returns status 2 and changes nothing.
- R9: lrn_ready_o is always high. rsp_valid_o is high exactly in the cycle after each accepted command, and only then.
- R10: A descriptor presented at clock edge k appears at the output after edge k+2. Descriptors leave one per cycle in input order, and out_tag_o equals the in_tag_i that was sent.
- R11: A lookup resolved at the same edge as a learn or unlearn sees the table as it was before the command. If a learn and a counter writeback target the same slot at that edge, the learn wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_field_en_i | input | 4 | Key slot enable mask |
| in_valid_i | input | 1 | Input descriptor valid |
| in_tag_i | input | 8 | Order tag of the descriptor |
| in_fields_i | input | 128 | Four extracted 32-bit field slots |
| in_len_i | input | 16 | Packet length in bytes |
| lrn_valid_i | input | 1 | Command valid |
| lrn_ready_o | output | 1 | Command accepted |
| lrn_op_i | input | 1 | 0 learn, 1 unlearn |
| lrn_fields_i | input | 128 | Field slots of the flow to learn or remove |
| lrn_drop_i | input | 1 | Action of the learned entry: 1 drop, 0 forward |
| lrn_port_i | input | 4 | Forward port of the learned entry |
| rsp_valid_o | output | 1 | Command status valid |
| rsp_status_o | output | 2 | 0 ok, 1 slot taken, 2 not found |
| out_valid_o | output | 1 | Output descriptor valid |
| out_tag_o | output | 8 | Tag of the output descriptor |
| out_dest_o | output | 2 | 0 drop, 1 forward, 2 host |
| out_port_o | output | 4 | Forward port |
| out_pkts_o | output | 32 | Flow packet count after this packet |
| out_bytes_o | output | 32 | Flow byte count after this packet |

## Verification
The embedded properties check on every cycle the fixed two-edge path from input to output and the one-cycle command response. They also check that a host verdict never carries counts or a port, that every hit carries a nonzero packet count, that no illegal destination code appears, and that a successful unlearn empties its slot. Key masking per profile, CRC placement and collisions, counter accumulation and clearing, and the ordering of a learn against a lookup in flight can only be shown by the bench. Its reference model tracks the table behaviourally and compares every output on every cycle through directed and mixed traffic.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [1:0] {
    DEST_DROP = 2'd0,
    DEST_FWD  = 2'd1,
    DEST_HOST = 2'd2
  } dest_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_COLLIDE  = 2'd1,
    ST_NOTFOUND = 2'd2
  } lrn_st_e;
endpackage

// File: rtl/flow_key_build.sv
module flow_key_build #(
  parameter int NF    = 4,
  parameter int FW    = 32,
  parameter int IDX_W = 6,
  localparam int KEY_W = NF * FW
) (
  input  logic [NF-1:0]    en_i,
  input  logic [KEY_W-1:0] fields_i,
  output logic [KEY_W-1:0] key_o,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [15:0] crc16(input logic [KEY_W-1:0] k);
    logic [15:0] c;
    logic        fb;
    c = 16'hFFFF;
    for (int b = KEY_W - 1; b >= 0; b--) begin
      fb = c[15] ^ k[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  for (genvar j = 0; j < NF; j++) begin : g_slot
    assign key_o[j*FW +: FW] = en_i[j] ? fields_i[j*FW +: FW] : '0;
  end

  assign idx_o = IDX_W'(crc16(key_o));
endmodule

// File: rtl/flow_table.sv
module flow_table
  import flow_pkg::*;
#(
  parameter int KEY_W  = 128,
  parameter int IDX_W  = 6,
  parameter int PORT_W = 4,
  parameter int CNT_W  = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // lookup read
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [KEY_W-1:0]  rd_key_i,
  output logic              hit_o,
  output logic              drop_o,
  output logic [PORT_W-1:0] port_o,
  output logic [CNT_W-1:0]  pkts_o,
  output logic [CNT_W-1:0]  bytes_o,
  // counter writeback
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [CNT_W-1:0]  wb_pkts_i,
  input  logic [CNT_W-1:0]  wb_bytes_i,
  // learn / unlearn
  input  logic              lrn_en_i,
  input  logic              lrn_op_i,
  input  logic [IDX_W-1:0]  lrn_idx_i,
  input  logic [KEY_W-1:0]  lrn_key_i,
  input  logic              lrn_drop_i,
  input  logic [PORT_W-1:0] lrn_port_i,
  output lrn_st_e           lrn_status_o
);
  logic              vld_q   [DEPTH];
  logic [KEY_W-1:0]  key_q   [DEPTH];
  logic              drop_q  [DEPTH];
  logic [PORT_W-1:0] port_q  [DEPTH];
  logic [CNT_W-1:0]  pkts_q  [DEPTH];
  logic [CNT_W-1:0]  bytes_q [DEPTH];

  logic lrn_same, lrn_wr, wb_do;

  assign hit_o   = vld_q[rd_idx_i] && (key_q[rd_idx_i] == rd_key_i);
  assign drop_o  = drop_q[rd_idx_i];
  assign port_o  = port_q[rd_idx_i];
  assign pkts_o  = pkts_q[rd_idx_i];
  assign bytes_o = bytes_q[rd_idx_i];

  assign lrn_same = vld_q[lrn_idx_i] && (key_q[lrn_idx_i] == lrn_key_i);

  always_comb begin
    if (!lrn_op_i) lrn_status_o = (!vld_q[lrn_idx_i] || lrn_same) ? ST_OK : ST_COLLIDE;
    else           lrn_status_o = lrn_same ? ST_OK : ST_NOTFOUND;
  end

  assign lrn_wr = lrn_en_i && (lrn_status_o == ST_OK);
  // command beats writeback on the same slot
  assign wb_do  = wb_en_i && !(lrn_wr && (lrn_idx_i == wb_idx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else if (lrn_wr) begin
      vld_q[lrn_idx_i] <= !lrn_op_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wb_do) begin
      pkts_q[wb_idx_i]  <= wb_pkts_i;
      bytes_q[wb_idx_i] <= wb_bytes_i;
    end
    if (lrn_wr && !lrn_op_i) begin
      key_q[lrn_idx_i]   <= lrn_key_i;
      drop_q[lrn_idx_i]  <= lrn_drop_i;
      port_q[lrn_idx_i]  <= lrn_port_i;
      pkts_q[lrn_idx_i]  <= '0;
      bytes_q[lrn_idx_i] <= '0;
    end
  end

  // R8: a successful unlearn leaves its slot empty
  p_unlearn_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrn_en_i && lrn_op_i && lrn_status_o == ST_OK) |=> !vld_q[$past(lrn_idx_i)]);
  // R7: a successful learn leaves its slot occupied
  p_learn_fills_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrn_en_i && !lrn_op_i && lrn_status_o == ST_OK) |=> vld_q[$past(lrn_idx_i)]);
endmodule

// File: rtl/flow_shunt.sv
module flow_shunt
  import flow_pkg::*;
#(
  parameter int NF     = 4,
  parameter int FW     = 32,
  parameter int IDX_W  = 6,
  parameter int PORT_W = 4,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int TAG_W  = 8,
  localparam int KEY_W = NF * FW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NF-1:0]     cfg_field_en_i,
  input  logic              in_valid_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [KEY_W-1:0]  in_fields_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic              lrn_valid_i,
  output logic              lrn_ready_o,
  input  logic              lrn_op_i,
  input  logic [KEY_W-1:0]  lrn_fields_i,
  input  logic              lrn_drop_i,
  input  logic [PORT_W-1:0] lrn_port_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic              out_valid_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [1:0]        out_dest_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic [CNT_W-1:0]  out_pkts_o,
  output logic [CNT_W-1:0]  out_bytes_o
);
  logic [KEY_W-1:0] lk_key, lr_key;
  logic [IDX_W-1:0] lk_idx, lr_idx;

  flow_key_build #(.NF(NF), .FW(FW), .IDX_W(IDX_W)) u_lk_key (
    .en_i(cfg_field_en_i), .fields_i(in_fields_i), .key_o(lk_key), .idx_o(lk_idx));
  flow_key_build #(.NF(NF), .FW(FW), .IDX_W(IDX_W)) u_lr_key (
    .en_i(cfg_field_en_i), .fields_i(lrn_fields_i), .key_o(lr_key), .idx_o(lr_idx));

  // stage 1: key and index registered
  logic             s1_valid;
  logic [TAG_W-1:0] s1_tag;
  logic [KEY_W-1:0] s1_key;
  logic [IDX_W-1:0] s1_idx;
  logic [LEN_W-1:0] s1_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_key   <= '0;
      s1_idx   <= '0;
      s1_len   <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_tag <= in_tag_i;
        s1_key <= lk_key;
        s1_idx <= lk_idx;
        s1_len <= in_len_i;
      end
    end
  end

  logic              t_hit, t_drop;
  logic [PORT_W-1:0] t_port;
  logic [CNT_W-1:0]  t_pkts, t_bytes, nx_pkts, nx_bytes;
  logic              lrn_en;
  lrn_st_e           lrn_st;

  assign lrn_ready_o = 1'b1;
  assign lrn_en      = lrn_valid_i && lrn_ready_o;
  assign nx_pkts     = t_pkts + CNT_W'(1);
  assign nx_bytes    = t_bytes + CNT_W'(s1_len);

  flow_table #(.KEY_W(KEY_W), .IDX_W(IDX_W), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i(s1_idx), .rd_key_i(s1_key),
    .hit_o(t_hit), .drop_o(t_drop), .port_o(t_port), .pkts_o(t_pkts), .bytes_o(t_bytes),
    .wb_en_i(s1_valid && t_hit), .wb_idx_i(s1_idx), .wb_pkts_i(nx_pkts), .wb_bytes_i(nx_bytes),
    .lrn_en_i(lrn_en), .lrn_op_i(lrn_op_i), .lrn_idx_i(lr_idx), .lrn_key_i(lr_key),
    .lrn_drop_i(lrn_drop_i), .lrn_port_i(lrn_port_i), .lrn_status_o(lrn_st));

  dest_e nx_dest;
  always_comb begin
    if (!t_hit)      nx_dest = DEST_HOST;
    else if (t_drop) nx_dest = DEST_DROP;
    else             nx_dest = DEST_FWD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_tag_o    <= '0;
      out_dest_o   <= DEST_HOST;
      out_port_o   <= '0;
      out_pkts_o   <= '0;
      out_bytes_o  <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_OK;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        out_tag_o   <= s1_tag;
        out_dest_o  <= nx_dest;
        out_port_o  <= (nx_dest == DEST_FWD) ? t_port : '0;
        out_pkts_o  <= t_hit ? nx_pkts : '0;
        out_bytes_o <= t_hit ? nx_bytes : '0;
      end
      rsp_valid_o <= lrn_en;
      if (lrn_en) rsp_status_o <= lrn_st;
    end
  end

  // R10: fixed two-edge latency, one in one out
  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o);
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o);
  // R9: one response per accepted command, next cycle
  p_rsp_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrn_valid_i && lrn_ready_o) |=> rsp_valid_o);
  p_rsp_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lrn_valid_i |=> !rsp_valid_o);
  // R5: host verdict carries no counts and no port
  p_host_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_dest_o == DEST_HOST) |-> (out_pkts_o == '0 && out_bytes_o == '0 && out_port_o == '0));
  // R6: a hit always reports at least this packet
  p_hit_counted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_dest_o != DEST_HOST) |-> out_pkts_o != '0);
  // R4: only legal destination codes
  p_dest_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_dest_o != 2'd3);
endmodule

// File: tb/sim_flow_shunt.sv
`timescale 1ns/1ps
module sim_flow_shunt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]   cfg;
  logic         iv, lv, lop, ldrop;
  logic [7:0]   itag;
  logic [127:0] ifl, lfl;
  logic [15:0]  ilen;
  logic [3:0]   lport;
  logic         lrdy, rv, ov;
  logic [1:0]   rs, odest;
  logic [7:0]   otag;
  logic [3:0]   oport;
  logic [31:0]  opk, oby;

  flow_shunt u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_field_en_i(cfg),
    .in_valid_i(iv), .in_tag_i(itag), .in_fields_i(ifl), .in_len_i(ilen),
    .lrn_valid_i(lv), .lrn_ready_o(lrdy), .lrn_op_i(lop), .lrn_fields_i(lfl),
    .lrn_drop_i(ldrop), .lrn_port_i(lport),
    .rsp_valid_o(rv), .rsp_status_o(rs),
    .out_valid_o(ov), .out_tag_o(otag), .out_dest_o(odest), .out_port_o(oport),
    .out_pkts_o(opk), .out_bytes_o(oby));

  int checks = 0, errors = 0;

  // behavioural model state
  bit           m_vld  [64];
  logic [127:0] m_key  [64];
  bit           m_drop [64];
  int           m_port [64];
  int unsigned  m_pk   [64];
  int unsigned  m_by   [64];
  bit           p_v;
  logic [127:0] p_key;
  int           p_len;
  int           p_tag;
  bit           e_ov, e_rv;
  int           e_tag, e_dest, e_port, e_rs;
  int unsigned  e_pk, e_by;
  bit           e_lop;
  int           tag_ctr = 0;

  function automatic logic [127:0] mk(int sip, int dip, int sp, int dp, int pr);
    return {24'd0, pr[7:0], sp[15:0], dp[15:0], dip[31:0], sip[31:0]};
  endfunction

  function automatic logic [127:0] msk(logic [127:0] f, logic [3:0] en);
    logic [127:0] r = '0;
    for (int j = 0; j < 4; j++) if (en[j]) r[j*32 +: 32] = f[j*32 +: 32];
    return r;
  endfunction

  function automatic int slot_of(logic [127:0] k);
    logic [15:0] c = 16'hFFFF;
    for (int b = 127; b >= 0; b--) begin
      bit t = c[15] ^ k[b];
      c = c << 1;
      if (t) c = c ^ 16'h1021;
    end
    return int'(c[5:0]);
  endfunction

  task automatic chk(string ph, string sub, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", ph, sub, act, exp);
    end
  endtask

  task automatic cyc(string ph, bit in_v, logic [127:0] f, int len,
                     bit l_v, bit l_op, logic [127:0] lf_in, bit l_drop, int l_port);
    iv = in_v; ifl = f; ilen = 16'(len); itag = 8'(tag_ctr);
    lv = l_v; lop = l_op; lfl = lf_in; ldrop = l_drop; lport = 4'(l_port);
    @(posedge clk);
    // resolve lookup in flight against pre-command table
    e_ov = p_v;
    if (p_v) begin
      int s = slot_of(p_key);
      e_tag = p_tag;
      if (m_vld[s] && m_key[s] == p_key) begin
        m_pk[s] += 1; m_by[s] += p_len;
        e_pk = m_pk[s]; e_by = m_by[s];
        e_dest = m_drop[s] ? 0 : 1; e_port = m_drop[s] ? 0 : m_port[s];
      end else begin
        e_dest = 2; e_port = 0; e_pk = 0; e_by = 0;
      end
    end
    e_rv = l_v; e_lop = l_op;
    if (l_v) begin
      logic [127:0] k = msk(lf_in, cfg);
      int s = slot_of(k);
      bit same = m_vld[s] && m_key[s] == k;
      if (!l_op) begin
        if (!m_vld[s] || same) begin
          m_vld[s] = 1; m_key[s] = k; m_drop[s] = l_drop; m_port[s] = l_port;
          m_pk[s] = 0; m_by[s] = 0; e_rs = 0;
        end else e_rs = 1;
      end else begin
        if (same) begin m_vld[s] = 0; e_rs = 0; end else e_rs = 2;
      end
    end
    p_v = in_v; p_key = msk(f, cfg); p_len = len; p_tag = tag_ctr & 255;
    if (in_v) tag_ctr++;
    @(negedge clk);
    chk(ph, "R10 valid", ov, e_ov);
    if (e_ov) begin
      chk(ph, "R10 tag", otag, e_tag);
      chk(ph, (e_dest == 2) ? "R5 dest" : "R4 dest", odest, e_dest);
      chk(ph, (e_dest == 2) ? "R5 port" : "R4 port", oport, e_port);
      chk(ph, "R6 pkts", opk, e_pk);
      chk(ph, "R6 bytes", oby, e_by);
    end
    chk(ph, "R9 rsp_valid", rv, e_rv);
    if (e_rv) chk(ph, e_lop ? "R8 status" : "R7 status", rs, e_rs);
    chk(ph, "R9 ready", lrdy, 1);
  endtask

  task automatic pkt(string ph, logic [127:0] f, int len);
    cyc(ph, 1, f, len, 0, 0, '0, 0, 0);
  endtask
  task automatic learn(string ph, logic [127:0] f, bit drop, int port);
    cyc(ph, 0, '0, 0, 1, 0, f, drop, port);
  endtask
  task automatic unlearn(string ph, logic [127:0] f);
    cyc(ph, 0, '0, 0, 1, 1, f, 0, 0);
  endtask
  task automatic idle(string ph, int n);
    for (int i = 0; i < n; i++) cyc(ph, 0, '0, 0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] fa, fb, fc, fd, fe, ff, ff_frag, fg, fg_pr, fg_pt;
    logic [127:0] fl [6];
    cfg = 4'b1111; iv = 0; lv = 0; lop = 0; ldrop = 0; lport = 0;
    ifl = '0; lfl = '0; ilen = 0; itag = 0;
    p_v = 0;
    for (int i = 0; i < 64; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", ov, 0);
    chk("R1", "rsp_valid", rv, 0);
    rst_n = 1;
    @(negedge clk);
    fa = mk(32'h0a000001, 32'h0a000002, 1000, 80, 6);
    fb = mk(32'h0b000001, 32'h0b000002, 2000, 53, 17);
    pkt("R1", fa, 64);
    idle("R1", 2);

    learn("R7", fa, 0, 3);
    pkt("R4", fa, 100);
    pkt("R6", fa, 200);
    pkt("R6", fa, 300);
    learn("R7", fb, 1, 5);
    pkt("R10", fb, 40);
    pkt("R10", fa, 50);
    pkt("R10", mk(1, 2, 3, 4, 5), 60);
    pkt("R10", fb, 70);
    idle("R10", 2);

    // R7: collision on the slot of fa
    fc = '0;
    for (int i = 1; i < 100000; i++) begin
      fc = mk(i, 32'h0c0c0c0c, 7, 9, 6);
      if (slot_of(msk(fc, 4'b1111)) == slot_of(msk(fa, 4'b1111))) break;
    end
    learn("R7", fc, 1, 2);
    pkt("R7", fc, 10);
    pkt("R7", fa, 10);
    // relearn of same key clears counters
    learn("R7", fa, 0, 6);
    pkt("R6", fa, 33);
    idle("R6", 2);

    // R8
    fd = mk(32'hdead0001, 32'hdead0002, 1, 1, 1);
    unlearn("R8", fd);
    unlearn("R8", fa);
    pkt("R8", fa, 20);
    idle("R8", 2);

    // R11: lookup in flight vs learn, and writeback vs relearn
    fe = mk(32'h0e0e0e0e, 32'h0e0e0e0f, 11, 12, 6);
    pkt("R11", fe, 90);
    cyc("R11", 1, fe, 91, 1, 0, fe, 0, 7);
    pkt("R11", fe, 92);
    cyc("R11", 1, fe, 93, 1, 0, fe, 0, 8);
    pkt("R11", fe, 94);
    cyc("R11", 1, fe, 95, 1, 1, fe, 0, 0);
    pkt("R11", fe, 96);
    idle("R11", 2);

    // R3: 2-tuple matches a fragment without ports
    cfg = 4'b0011;
    ff = mk(32'hc0a80001, 32'hc0a80002, 16'h1234, 16'h5678, 6);
    ff_frag = mk(32'hc0a80001, 32'hc0a80002, 0, 0, 17);
    learn("R3", ff, 0, 9);
    pkt("R3", ff_frag, 1500);
    pkt("R2", ff, 60);
    idle("R3", 2);
    // R2: 4-tuple ignores protocol but not ports
    cfg = 4'b0111;
    fg = mk(32'h0f000001, 32'h0f000002, 443, 5000, 6);
    fg_pr = mk(32'h0f000001, 32'h0f000002, 443, 5000, 17);
    fg_pt = mk(32'h0f000001, 32'h0f000002, 444, 5000, 6);
    learn("R2", fg, 0, 1);
    pkt("R2", fg_pr, 77);
    pkt("R2", fg_pt, 78);
    pkt("R2", fg, 79);
    idle("R2", 2);

    // mixed traffic under the 5-tuple profile
    cfg = 4'b1111;
    for (int i = 0; i < 6; i++) fl[i] = mk(32'h20000000 + i * 7, 32'h30000000 + i, 100 + i, 200, 6);
    for (int i = 0; i < 400; i++) begin
      int a = $urandom_range(0, 5);
      int b = $urandom_range(0, 5);
      bit v = ($urandom_range(0, 3) != 0);
      bit l = ($urandom_range(0, 4) == 0);
      cyc("R10", v, fl[a], $urandom_range(40, 1500), l, ($urandom_range(0, 2) == 0),
          fl[b], $urandom_range(0, 1), $urandom_range(0, 15));
    end
    idle("R10", 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule